// File: doc/BRIEF.md
# Load/Store Addressing and Writeback Unit

This block handles a single-register memory transfer. It takes a five-bit mode selector, a family select, a base register value and the offset sources. From these it forms the effective address, the access size, the direction and the privilege override, and it issues one memory request. When the response returns, it reports the destination-register write and the base-register update.

Two encoding families are supported. The word/byte family uses either a register offset or a 12-bit immediate. The halfword/signed family uses either a register offset or an 8-bit immediate built from two 4-bit fields. In the halfword family, a separate kind field selects unsigned halfword, signed byte or signed halfword.

An instruction whose condition failed, an undefined combination, or a faulting access finishes without any register side effect. Every instruction ends with a one-cycle completion pulse.

Top module: `ldst_addr_unit`

## Requirements
- R1: The mode selector is laid out as P at bit 4, U at bit 3, B/I at bit 2, W at bit 1 and L at bit 0. `family`=0 selects word/byte and `family`=1 selects halfword/signed.
- R2: With U=1 the offset is added to the base, and with U=0 it is subtracted, modulo 2^32. In the word/byte family the offset is `rm_val` when `off_is_reg`=1 and the zero-extended `imm12` otherwise.
- R3: With P=1 the request address is base ± offset. With P=0 it is the unmodified base.
- R4: The base register is written with base ± offset when P=0 or W=1, and is left alone otherwise.
- R5: In the word/byte family, P=0 with W=0 raises `mem_unpriv`. In every other case `mem_unpriv` is 0.
- R6: `mem_size` is 0 for a byte, 1 for a halfword and 2 for a word. In the word/byte family, B=1 selects a byte that is zero-extended on load, and B=0 selects a word. In the halfword family, `hw_kind` 1 is an unsigned halfword, 2 a sign-extended byte and 3 a sign-extended halfword.
- R7: L=1 reads memory (`mem_write`=0) and writes the destination register with the extended data. L=0 writes `store_val`, masked to the access size, on `mem_wdata`.
- R8: In the halfword family, I=1 uses the offset {imm_hi, imm_lo}, zero-extended, and I=0 uses `rm_val`.
- R9: In the halfword family, P=0 with W=1, `hw_kind`=0, or a store with `hw_kind`≠1 is undefined. It issues no request, raises `undef` with `done`, and writes no register.
- R10: With `cond_pass`=0 there is no request, no destination write and no base write. Only `done` is pulsed.
- R11: A response with `mem_rsp_fault`=1 suppresses both the destination write and the base write.
- R12: `in_ready` is high only while idle. A request holds its address, data and attributes stable until `mem_req_ready` is sampled high.
- R13: For a load with writeback where `rd_idx` equals `rn_idx`, only the destination write is performed, and it carries the loaded value.
- R14: `done` and the register writes are high for exactly one cycle. That cycle follows the response edge, or, for a skipped instruction, it follows the accept edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and accepting |
| family | input | 1 | 0 word/byte, 1 halfword/signed |
| mode | input | 5 | Selector {P,U,B/I,W,L} |
| hw_kind | input | 2 | Halfword-family transfer kind |
| off_is_reg | input | 1 | Word/byte family register offset select |
| cond_pass | input | 1 | Condition predicate result |
| base_val | input | 32 | Base register value |
| rm_val | input | 32 | Offset register value |
| imm12 | input | 12 | Word/byte immediate |
| imm_hi | input | 4 | Halfword immediate high nibble |
| imm_lo | input | 4 | Halfword immediate low nibble |
| rd_idx | input | 4 | Destination/source register index |
| rn_idx | input | 4 | Base register index |
| store_val | input | 32 | Value of the source register for stores |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_addr | output | 32 | Effective address |
| mem_size | output | 2 | 0 byte, 1 half, 2 word |
| mem_write | output | 1 | 1 store, 0 load |
| mem_unpriv | output | 1 | User-privilege access |
| mem_wdata | output | 32 | Store data masked to size |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_fault | input | 1 | Response carries a fault |
| mem_rsp_data | input | 32 | Read data, right-aligned |
| done | output | 1 | Instruction finished |
| undef | output | 1 | Instruction was undefined (with done) |
| rd_we | output | 1 | Destination write enable |
| rd_wr_idx | output | 4 | Destination index |
| rd_wdata | output | 32 | Destination value |
| rn_we | output | 1 | Base writeback enable |
| rn_wr_idx | output | 4 | Base index |
| rn_wdata | output | 32 | Updated base value |

## Verification
The request is due one cycle after the accept edge. It stays stable for every cycle in which ready is held low, so it is sampled on the falling edge after the accept and again on each stalled cycle. The completion pulse and the register writes are due one cycle after the response edge, or one cycle after the accept edge for a skipped instruction. The bench samples them on that falling edge, then confirms one cycle later that they have dropped and that the unit is idle. The sweep covers every selector value in both families, under every offset source or transfer kind, with the condition passing or failing and with or without a fault.

// File: rtl/ldst_addr_unit.sv
module ldst_addr_unit #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int IMM_W  = 12,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              family,
  input  logic [4:0]        mode,
  input  logic [1:0]        hw_kind,
  input  logic              off_is_reg,
  input  logic              cond_pass,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [IMM_W-1:0]  imm12,
  input  logic [NIB_W-1:0]  imm_hi,
  input  logic [NIB_W-1:0]  imm_lo,
  input  logic [REG_W-1:0]  rd_idx,
  input  logic [REG_W-1:0]  rn_idx,
  input  logic [DATA_W-1:0] store_val,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [DATA_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic              mem_write,
  output logic              mem_unpriv,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_fault,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              undef,
  output logic              rd_we,
  output logic [REG_W-1:0]  rd_wr_idx,
  output logic [DATA_W-1:0] rd_wdata,
  output logic              rn_we,
  output logic [REG_W-1:0]  rn_wr_idx,
  output logic [DATA_W-1:0] rn_wdata
);

  localparam int SPLIT_W = 2 * NIB_W;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_FIN} state_t;
  typedef enum logic [2:0] {EX_WORD, EX_ZB, EX_ZH, EX_SB, EX_SH} ext_t;

  state_t state;

  wire bit_p = mode[4];
  wire bit_u = mode[3];
  wire bit_x = mode[2];
  wire bit_w = mode[1];
  wire bit_l = mode[0];

  logic [DATA_W-1:0] off_c;
  logic [DATA_W-1:0] sum_c;
  logic              undef_c;
  logic [1:0]        size_c;
  ext_t              ext_c;
  logic [DATA_W-1:0] wmask_c;

  always_comb begin
    if (family)
      off_c = bit_x ? DATA_W'({imm_hi, imm_lo}) : rm_val;
    else
      off_c = off_is_reg ? rm_val : DATA_W'(imm12);
  end

  assign sum_c = bit_u ? (base_val + off_c) : (base_val - off_c);

  always_comb begin
    undef_c = 1'b0;
    if (family) begin
      casez (mode)
        5'b0??1?: undef_c = 1'b1;
        default:  undef_c = 1'b0;
      endcase
      if (hw_kind == 2'd0) undef_c = 1'b1;
      if (!bit_l && hw_kind != 2'd1) undef_c = 1'b1;
    end
  end

  always_comb begin
    if (!family) begin
      size_c = bit_x ? SZ_BYTE : SZ_WORD;
      ext_c  = bit_x ? EX_ZB : EX_WORD;
    end else begin
      case (hw_kind)
        2'd2:    begin size_c = SZ_BYTE; ext_c = EX_SB; end
        2'd3:    begin size_c = SZ_HALF; ext_c = EX_SH; end
        default: begin size_c = SZ_HALF; ext_c = EX_ZH; end
      endcase
    end
  end

  always_comb begin
    case (size_c)
      SZ_BYTE: wmask_c = DATA_W'({8{1'b1}});
      SZ_HALF: wmask_c = DATA_W'({16{1'b1}});
      default: wmask_c = {DATA_W{1'b1}};
    endcase
  end

  logic              go_q, undef_q, load_q, wb_q, fault_q;
  ext_t              ext_q;
  logic [DATA_W-1:0] sum_q, ld_q;
  logic [REG_W-1:0]  rd_q, rn_q;

  wire accept = in_valid && (state == ST_IDLE);
  wire skip_c = undef_c || !cond_pass;

  logic [DATA_W-1:0] ld_ext;
  always_comb begin
    case (ext_q)
      EX_ZB:   ld_ext = DATA_W'(mem_rsp_data[7:0]);
      EX_ZH:   ld_ext = DATA_W'(mem_rsp_data[15:0]);
      EX_SB:   ld_ext = {{(DATA_W-8){mem_rsp_data[7]}}, mem_rsp_data[7:0]};
      EX_SH:   ld_ext = {{(DATA_W-16){mem_rsp_data[15]}}, mem_rsp_data[15:0]};
      default: ld_ext = mem_rsp_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      go_q       <= 1'b0;
      undef_q    <= 1'b0;
      load_q     <= 1'b0;
      wb_q       <= 1'b0;
      fault_q    <= 1'b0;
      ext_q      <= EX_WORD;
      sum_q      <= '0;
      ld_q       <= '0;
      rd_q       <= '0;
      rn_q       <= '0;
      mem_addr   <= '0;
      mem_size   <= SZ_WORD;
      mem_write  <= 1'b0;
      mem_unpriv <= 1'b0;
      mem_wdata  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          go_q       <= !skip_c;
          undef_q    <= undef_c;
          load_q     <= bit_l;
          wb_q       <= !bit_p || bit_w;
          fault_q    <= 1'b0;
          ext_q      <= ext_c;
          sum_q      <= sum_c;
          rd_q       <= rd_idx;
          rn_q       <= rn_idx;
          mem_addr   <= bit_p ? sum_c : base_val;
          mem_size   <= size_c;
          mem_write  <= !bit_l;
          mem_unpriv <= !family && !bit_p && !bit_w;
          mem_wdata  <= store_val & wmask_c;
          state      <= skip_c ? ST_FIN : ST_REQ;
        end
        ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          fault_q <= mem_rsp_fault;
          ld_q    <= ld_ext;
          state   <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  wire fin = (state == ST_FIN);
  wire ok  = fin && go_q && !fault_q;

  assign in_ready      = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign done          = fin;
  assign undef         = fin && undef_q;
  assign rd_we         = ok && load_q;
  assign rd_wr_idx     = rd_q;
  assign rd_wdata      = ld_q;
  assign rn_we         = ok && wb_q && !(load_q && rd_q == rn_q);
  assign rn_wr_idx     = rn_q;
  assign rn_wdata      = sum_q;

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_wdata) && $stable(mem_size) && $stable(mem_write));

  assert_idle_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && (mem_req_valid || done)));

  assert_undef_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> done && !rd_we && !rn_we);

  assert_writes_at_done_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we || rn_we) |-> done);

  assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && in_ready);

  assert_same_reg_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we && rn_we |-> rd_wr_idx != rn_wr_idx);

  assert_unpriv_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_unpriv |-> mem_size != SZ_HALF);

endmodule

// File: tb/ldst_addr_unit_tb.sv
module ldst_addr_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        in_valid = 0, family = 0, off_is_reg = 0, cond_pass = 0;
  logic [4:0]  mode = '0;
  logic [1:0]  hw_kind = '0;
  logic [31:0] base_val = '0, rm_val = '0, store_val = '0, mem_rsp_data = '0;
  logic [11:0] imm12 = '0;
  logic [3:0]  imm_hi = '0, imm_lo = '0, rd_idx = '0, rn_idx = '0;
  logic        mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_fault = 0;
  logic        in_ready, mem_req_valid, mem_write, mem_unpriv, done, undef, rd_we, rn_we;
  logic [31:0] mem_addr, mem_wdata, rd_wdata, rn_wdata;
  logic [1:0]  mem_size;
  logic [3:0]  rd_wr_idx, rn_wr_idx;

  ldst_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .family(family), .mode(mode), .hw_kind(hw_kind), .off_is_reg(off_is_reg),
    .cond_pass(cond_pass), .base_val(base_val), .rm_val(rm_val), .imm12(imm12),
    .imm_hi(imm_hi), .imm_lo(imm_lo), .rd_idx(rd_idx), .rn_idx(rn_idx),
    .store_val(store_val), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_write(mem_write),
    .mem_unpriv(mem_unpriv), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_fault(mem_rsp_fault), .mem_rsp_data(mem_rsp_data), .done(done),
    .undef(undef), .rd_we(rd_we), .rd_wr_idx(rd_wr_idx), .rd_wdata(rd_wdata),
    .rn_we(rn_we), .rn_wr_idx(rn_wr_idx), .rn_wdata(rn_wdata)
  );

  int nchk = 0, nfail = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h (family=%0d mode=%b kind=%0d)",
               tag, act, exp, family, mode, hw_kind);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic run_one(input logic fam, input logic [4:0] m, input logic [1:0] kind,
                         input logic oreg, input logic cp, input logic flt, input int dly);
    logic p, u, x, w, l, und, skip, wb;
    logic [31:0] off, sum, eaddr, mask, ld, rsp;
    logic [1:0] sz;
    seed = nxt(seed); base_val = (m[3] == 1'b0 && seed[0]) ? 32'h4 : seed;
    seed = nxt(seed); rm_val = seed;
    seed = nxt(seed); imm12 = seed[11:0]; imm_hi = seed[15:12]; imm_lo = seed[19:16];
    seed = nxt(seed); store_val = seed;
    seed = nxt(seed); rsp = seed;
    rd_idx = seed[7:4];
    rn_idx = (seed[9:8] == 2'b00) ? seed[7:4] : seed[7:4] + 4'd1;
    family = fam; mode = m; hw_kind = kind; off_is_reg = oreg; cond_pass = cp;
    {p, u, x, w, l} = m;
    if (fam) off = x ? {24'd0, imm_hi, imm_lo} : rm_val;
    else     off = oreg ? rm_val : {20'd0, imm12};
    sum   = u ? base_val + off : base_val - off;
    eaddr = p ? sum : base_val;
    und   = fam && ((!p && w) || kind == 2'd0 || (!l && kind != 2'd1));
    skip  = und || !cp;
    wb    = !p || w;
    if (!fam) sz = x ? 2'd0 : 2'd2;
    else      sz = (kind == 2'd2) ? 2'd0 : 2'd1;
    mask = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (!fam) ld = x ? {24'd0, rsp[7:0]} : rsp;
    else if (kind == 2'd2) ld = {{24{rsp[7]}}, rsp[7:0]};
    else if (kind == 2'd3) ld = {{16{rsp[15]}}, rsp[15:0]};
    else ld = {16'd0, rsp[15:0]};

    chk("R12 in_ready idle", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    if (skip) begin
      chk(und ? "R9 no request" : "R10 no request", {31'd0, mem_req_valid}, 32'd0);
      chk("R14 done after accept", {31'd0, done}, 32'd1);
      chk("R9 undef flag", {31'd0, undef}, {31'd0, und});
      chk(und ? "R9 rd_we" : "R10 rd_we", {31'd0, rd_we}, 32'd0);
      chk(und ? "R9 rn_we" : "R10 rn_we", {31'd0, rn_we}, 32'd0);
    end else begin
      chk("R12 request valid", {31'd0, mem_req_valid}, 32'd1);
      chk(fam ? "R1 R2 R3 R8 address" : "R1 R2 R3 address", mem_addr, eaddr);
      chk("R6 size", {30'd0, mem_size}, {30'd0, sz});
      chk("R7 direction", {31'd0, mem_write}, {31'd0, !l});
      chk("R5 unprivileged", {31'd0, mem_unpriv}, {31'd0, !fam && !p && !w});
      chk("R7 store data", mem_wdata, store_val & mask);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk("R12 held address", mem_addr, eaddr);
        chk("R12 held valid", {31'd0, mem_req_valid}, 32'd1);
      end
      mem_req_ready = 1'b1;
      @(posedge clk); #1 mem_req_ready = 1'b0;
      @(negedge clk);
      chk("R12 request dropped", {31'd0, mem_req_valid}, 32'd0);
      repeat (dly) @(negedge clk);
      mem_rsp_valid = 1'b1; mem_rsp_fault = flt; mem_rsp_data = rsp;
      @(posedge clk); #1 mem_rsp_valid = 1'b0; mem_rsp_fault = 1'b0;
      @(negedge clk);
      chk("R14 done after response", {31'd0, done}, 32'd1);
      chk("R9 no undef", {31'd0, undef}, 32'd0);
      chk(flt ? "R11 rd_we" : "R7 rd_we", {31'd0, rd_we}, {31'd0, !flt && l});
      chk((l && wb && rd_idx == rn_idx) ? "R13 rn_we" : (flt ? "R11 rn_we" : "R4 rn_we"),
          {31'd0, rn_we}, {31'd0, !flt && wb && !(l && rd_idx == rn_idx)});
      if (!flt && l) begin
        chk("R6 R7 load value", rd_wdata, ld);
        chk("R13 rd index", {28'd0, rd_wr_idx}, {28'd0, rd_idx});
      end
      if (!flt && wb) chk("R2 R4 base value", rn_wdata, sum);
    end
    @(negedge clk);
    chk("R14 single pulse", {31'd0, done || rd_we || rn_we}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset in_ready", {31'd0, in_ready}, 32'd1);
    chk("R12 reset request", {31'd0, mem_req_valid}, 32'd0);
    chk("R14 reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int fam = 0; fam < 2; fam++)
      for (int m = 0; m < 32; m++)
        for (int v = 0; v < (fam ? 4 : 2); v++)
          for (int c = 0; c < 4; c++)
            run_one(fam[0], m[4:0], v[1:0], v[0], c != 3, c == 2, (m + c) % 3);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule